// File: doc/BRIEF.md
# Peripheral Bidirectional Data Buffer

The block sits between the microcontroller data bus and one 8-bit I/O port. A single enable bit in an 8-bit mode register switches the whole port from its normal general-purpose role into a tri-state data buffer for an external peripheral. In buffer mode, the direction follows the bus strobes. A write pushes MCU data out onto the port pins. A read returns the pin levels on the read-data bus. Both directions are gated by two peripheral-select terms, and either one alone opens the buffer.

When buffer mode is off, the pins carry the general-purpose output value and output enable that arrive on pass-through inputs, and the pin levels are forwarded back as general-purpose input. The direction, the driven data and the read data are registered once, so the port responds one clock after the strobes. A strobe conflict, with read and write asserted together, leaves both sides undriven and sets a sticky error flag.

Top module: `pbuf_top`

## Requirements
- R1: After reset the mode register reads 00h, buffer mode is off, `err_o` is 0 and `bus_rdata_o` is 00h.
- R2: A cycle with `cfg_we_i` high loads `cfg_wdata_i` into the mode register, visible on `mode_o` after that clock edge. Bit 7 of the register enables buffer mode.
- R3: With buffer mode off, `pad_o` equals `gpio_out_i`, `pad_oe_o` equals `gpio_oe_i`, and `gpio_in_o` equals `pad_i`, all in the same cycle.
- R4: With buffer mode on, the general-purpose inputs have no effect on the pins, and `gpio_in_o` reads 00h.
- R5: With buffer mode on and neither select bit of `psel_i` high at a clock edge, `pad_oe_o` is all zeros and `bus_rdata_o` is 00h after that edge.
- R6: With buffer mode on, a select active and only `bus_wr_i` high at an edge, `pad_oe_o` is all ones and `pad_o` equals the `bus_wdata_i` sampled at that edge.
- R7: With buffer mode on, a select active and only `bus_rd_i` high at an edge, `bus_rdata_o` equals `pad_i` sampled at that edge, and `pad_oe_o` is all zeros.
- R8: `psel_i` bit 0 alone and `psel_i` bit 1 alone each open the buffer.
- R9: With buffer mode on, a select active and both strobes high at an edge, nothing is driven after that edge (`pad_oe_o` zeros, `bus_rdata_o` 00h). `err_o` becomes 1 and stays 1 until reset.
- R10: A strobe conflict while buffer mode is off, or while no select is active, does not set `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write value |
| mode_o | output | 8 | Mode register contents |
| bus_rd_i | input | 1 | MCU read strobe |
| bus_wr_i | input | 1 | MCU write strobe |
| psel_i | input | 2 | Peripheral select terms |
| bus_wdata_i | input | 8 | MCU write data |
| bus_rdata_o | output | 8 | Read data toward the MCU |
| pad_i | input | 8 | Port pin levels |
| pad_o | output | 8 | Port pin drive value |
| pad_oe_o | output | 8 | Port pin output enable |
| gpio_out_i | input | 8 | General-purpose output value |
| gpio_oe_i | input | 8 | General-purpose output enable |
| gpio_in_o | output | 8 | General-purpose input value |
| err_o | output | 1 | Sticky strobe-conflict flag |

## Verification
A wrong direction state shows up one clock after the strobe edge. It appears either as pins enabled during a read or idle cycle, or as pins left floating during a write. A stale or wrong read register shows up on `bus_rdata_o` in the same cycle. A mode register that holds the wrong value shows up immediately as a wrong mux choice between general-purpose and buffer signals. A lost or spurious error bit shows up on `err_o` one clock after the conflicting edge, and it persists, so any later sample exposes it. The mix of random strobes, selects and mode writes reaches every direction transition within a few hundred cycles.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned SEL_N    = 2;
  localparam int unsigned EN_BIT   = 7;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_WR   = 2'd1,
    DIR_RD   = 2'd2,
    DIR_BAD  = 2'd3
  } dir_e;
endpackage

// File: rtl/pbuf_mode_reg.sv
module pbuf_mode_reg #(
  parameter int unsigned W      = 8,
  parameter int unsigned EN_BIT = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mode_o,
  output logic         en_o
);
  logic [W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  assign mode_o = mode_q;
  assign en_o   = mode_q[EN_BIT];
endmodule

// File: rtl/pbuf_dir_ctrl.sv
module pbuf_dir_ctrl
  import pbuf_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_N-1:0] psel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pad_i,
  output logic             drv_o,
  output logic [W-1:0]     data_o,
  output logic [W-1:0]     rdata_o,
  output logic             err_o
);
  dir_e         dir_d;
  logic         sel;
  logic         drv_q, err_q;
  logic [W-1:0] data_q, rdata_q;

  assign sel = |psel_i;

  always_comb begin
    dir_d = DIR_IDLE;
    if (en_i && sel) begin
      unique case ({rd_i, wr_i})
        2'b01:   dir_d = DIR_WR;
        2'b10:   dir_d = DIR_RD;
        2'b11:   dir_d = DIR_BAD;
        default: dir_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q   <= 1'b0;
      data_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      drv_q   <= (dir_d == DIR_WR);
      rdata_q <= (dir_d == DIR_RD) ? pad_i : '0;
      if (dir_d == DIR_WR)  data_q <= wdata_i;
      if (dir_d == DIR_BAD) err_q  <= 1'b1;
    end
  end

  assign drv_o   = drv_q;
  assign data_o  = data_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pbuf_pin_mux.sv
module pbuf_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         drv_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] gpio_out_i,
  input  logic [W-1:0] gpio_oe_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] gpio_in_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_o[i]     = en_i ? data_i[i] : gpio_out_i[i];
    assign pad_oe_o[i]  = en_i ? drv_i     : gpio_oe_i[i];
    // general input path is cut while the port serves the peripheral
    assign gpio_in_o[i] = pad_i[i] & ~en_i;
  end
endmodule

// File: rtl/pbuf_top.sv
module pbuf_top
  import pbuf_pkg::*;
#(
  parameter int unsigned W      = PORT_W,
  parameter int unsigned NSEL   = SEL_N,
  parameter int unsigned MODE_EN = EN_BIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      mode_o,
  input  logic            bus_rd_i,
  input  logic            bus_wr_i,
  input  logic [NSEL-1:0] psel_i,
  input  logic [W-1:0]    bus_wdata_i,
  output logic [W-1:0]    bus_rdata_o,
  input  logic [W-1:0]    pad_i,
  output logic [W-1:0]    pad_o,
  output logic [W-1:0]    pad_oe_o,
  input  logic [W-1:0]    gpio_out_i,
  input  logic [W-1:0]    gpio_oe_i,
  output logic [W-1:0]    gpio_in_o,
  output logic            err_o
);
  logic         en;
  logic         drv;
  logic [W-1:0] data;

  pbuf_mode_reg #(.W(8), .EN_BIT(MODE_EN)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_o  (mode_o),
    .en_o    (en)
  );

  pbuf_dir_ctrl #(.W(W), .SEL_N(NSEL)) u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .psel_i  (psel_i),
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .pad_i   (pad_i),
    .drv_o   (drv),
    .data_o  (data),
    .rdata_o (bus_rdata_o),
    .err_o   (err_o)
  );

  pbuf_pin_mux #(.W(W)) u_mux (
    .en_i       (en),
    .drv_i      (drv),
    .data_i     (data),
    .gpio_out_i (gpio_out_i),
    .gpio_oe_i  (gpio_oe_i),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o),
    .gpio_in_o  (gpio_in_o)
  );
endmodule

// File: rtl/pbuf_chk.sv
module pbuf_chk #(
  parameter int unsigned W    = 8,
  parameter int unsigned NSEL = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [7:0]      mode_o,
  input logic            bus_rd_i,
  input logic            bus_wr_i,
  input logic [NSEL-1:0] psel_i,
  input logic [W-1:0]    bus_wdata_i,
  input logic [W-1:0]    bus_rdata_o,
  input logic [W-1:0]    pad_i,
  input logic [W-1:0]    pad_o,
  input logic [W-1:0]    pad_oe_o,
  input logic [W-1:0]    gpio_out_i,
  input logic [W-1:0]    gpio_oe_i,
  input logic [W-1:0]    gpio_in_o,
  input logic            err_o
);
  logic on_hold;
  assign on_hold = mode_o[7] && !cfg_we_i;

  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[7] |-> (pad_oe_o == gpio_oe_i && pad_o == gpio_out_i && gpio_in_o == pad_i));

  a_r4_gpio_in_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7] |-> gpio_in_o == '0);

  a_r5_idle_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_hold && psel_i == '0) |=> (pad_oe_o == '0 && bus_rdata_o == '0));

  a_r6_write_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_hold && |psel_i && bus_wr_i && !bus_rd_i)
      |=> (pad_oe_o == '1 && pad_o == $past(bus_wdata_i)));

  a_r7_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_hold && |psel_i && bus_rd_i && !bus_wr_i)
      |=> (pad_oe_o == '0 && bus_rdata_o == $past(pad_i)));

  a_r9_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_hold && |psel_i && bus_rd_i && bus_wr_i)
      |=> (err_o && pad_oe_o == '0 && bus_rdata_o == '0));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r10_no_false_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && !(mode_o[7] && |psel_i && bus_rd_i && bus_wr_i)) |=> !err_o);
endmodule

bind pbuf_top pbuf_chk #(.W(W), .NSEL(NSEL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .mode_o      (mode_o),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .psel_i      (psel_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .gpio_out_i  (gpio_out_i),
  .gpio_oe_i   (gpio_oe_i),
  .gpio_in_o   (gpio_in_o),
  .err_o       (err_o)
);

// File: tb/tb_pbuf_top.sv
`timescale 1ns/1ps
module tb_pbuf_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] mode_o;
  logic       bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [1:0] psel_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o;
  logic [7:0] pad_i = '0, pad_o, pad_oe_o;
  logic [7:0] gpio_out_i = '0, gpio_oe_i = '0, gpio_in_o;
  logic       err_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // bench model state
  logic [7:0] m_mode = '0;
  logic       m_drv = 1'b0;
  logic [7:0] m_data = '0;
  logic [7:0] m_rdata = '0;
  logic       m_err = 1'b0;

  always #5 clk_i = ~clk_i;

  pbuf_top dut (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] dir_of(input logic en, input logic [1:0] ps,
                                        input logic rd, input logic wr);
    if (!(en && |ps)) return 2'd0;
    return {rd, wr};
  endfunction

  // apply inputs at negedge, clock once, update model, check at next negedge
  task automatic step(input logic we, input logic [7:0] cw, input logic rd,
                      input logic wr, input logic [1:0] ps, input logic [7:0] wd,
                      input logic [7:0] pad, input logic [7:0] go, input logic [7:0] ge);
    logic [1:0] d;
    logic en;
    cfg_we_i = we; cfg_wdata_i = cw; bus_rd_i = rd; bus_wr_i = wr;
    psel_i = ps; bus_wdata_i = wd; pad_i = pad; gpio_out_i = go; gpio_oe_i = ge;
    @(posedge clk_i);
    d = dir_of(m_mode[7], ps, rd, wr);
    m_drv   = (d == 2'b01);
    if (d == 2'b01) m_data = wd;
    m_rdata = (d == 2'b10) ? pad : 8'h00;
    if (d == 2'b11) m_err = 1'b1;
    if (we) m_mode = cw;
    @(negedge clk_i);
    en = m_mode[7];
    chk("R2 mode", mode_o, m_mode);
    if (!en) begin
      chk("R3 pad_oe", pad_oe_o, ge);
      chk("R3 pad_o", pad_o, go);
      chk("R3 gpio_in", gpio_in_o, pad);
    end else begin
      chk(m_drv ? "R6 pad_oe" : "R5/R7/R9 pad_oe", pad_oe_o, {8{m_drv}});
      if (m_drv) chk("R6 pad_o", pad_o, m_data);
      chk("R4 gpio_in", gpio_in_o, 8'h00);
    end
    chk("R7 rdata", bus_rdata_o, m_rdata);
    chk("R9 err", {7'd0, err_o}, {7'd0, m_err});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    #12;
    // R1 reset state
    chk("R1 mode", mode_o, 8'h00);
    chk("R1 err", {7'd0, err_o}, 8'h00);
    chk("R1 rdata", bus_rdata_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    // R3 disabled pass-through
    step(0, 0, 0, 0, 2'b00, 8'h00, 8'h3C, 8'hA5, 8'h0F);
    // R10 conflict while disabled, then with no select when enabled
    step(0, 0, 1, 1, 2'b11, 8'h11, 8'h22, 8'h00, 8'hFF);
    chk("R10 err off", {7'd0, err_o}, 8'h00);
    step(1, 8'h80, 0, 0, 2'b00, 8'h00, 8'h00, 8'hFF, 8'hFF);  // R2 enable
    step(0, 0, 1, 1, 2'b00, 8'h55, 8'h66, 8'hFF, 8'hFF);
    chk("R10 err unsel", {7'd0, err_o}, 8'h00);
    // R4 gpio inputs ignored, R8 each select alone
    step(0, 0, 0, 1, 2'b01, 8'hC3, 8'h00, 8'h00, 8'h00);
    chk("R8 psel0 oe", pad_oe_o, 8'hFF);
    chk("R8 psel0 data", pad_o, 8'hC3);
    step(0, 0, 0, 1, 2'b10, 8'h5A, 8'h00, 8'hFF, 8'h00);
    chk("R8 psel1 data", pad_o, 8'h5A);
    step(0, 0, 1, 0, 2'b10, 8'h00, 8'h96, 8'h00, 8'hFF);
    chk("R7 read", bus_rdata_o, 8'h96);
    step(0, 0, 1, 0, 2'b00, 8'h00, 8'h77, 8'h00, 8'hFF);
    chk("R5 unsel rdata", bus_rdata_o, 8'h00);
    step(0, 0, 1, 1, 2'b01, 8'hEE, 8'hDD, 8'h00, 8'hFF);
    chk("R9 conflict err", {7'd0, err_o}, 8'h01);
    chk("R9 conflict oe", pad_oe_o, 8'h00);
    step(0, 0, 0, 0, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R9 sticky", {7'd0, err_o}, 8'h01);
    // R1 reset clears error and mode
    rst_ni = 1'b0; m_mode = '0; m_drv = 0; m_rdata = '0; m_err = 0;
    #1;
    chk("R1 re-reset err", {7'd0, err_o}, 8'h00);
    chk("R1 re-reset mode", mode_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    // random traffic, conflicts rare so the error flag stays clear a while
    for (int i = 0; i < 600; i++) begin
      logic we, rd, wr;
      logic [7:0] cw;
      we = ($urandom % 10) == 0;
      cw = {($urandom % 4) != 0, 7'($urandom)};
      rd = $urandom % 2;
      wr = ($urandom % 3) == 0;
      if (rd && wr && ($urandom % 8) != 0) rd = 0;
      step(we, cw, rd, wr, 2'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule